// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between an on-chip request port and an external asynchronous static RAM of 262,144 bytes. A client offers one read or write at a time with a valid/ready handshake. The block turns it into a timed sequence on the memory pins: an 18-bit address, an active-low and an active-high chip select, an active-low output enable and an active-low write enable. The shared 8-bit data bus is split into a driven value, a driver enable and a sampled input.

Every memory timing minimum is given to the block as a parameter in nanoseconds, next to the clock period. The block rounds each one up to whole cycles. With the default 5 ns clock, a read holds the memory selected for 11 cycles and then waits 4 cycles for the output to float. A write holds write enable low for 10 cycles, then keeps the chip selected and the data driven for one more cycle. Between requests the memory is deselected and the block drives nothing onto the bus.

The block reports a read by pulsing `rd_valid` for one cycle with the byte on `rd_data`. It reports a write by pulsing `wr_done` for one cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While idle, and during reset, the block holds `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0, with `req_ready`=1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the transaction ends. `mem_addr` and `mem_dq_out` keep the values captured at acceptance, whatever the request inputs do in the meantime.
- R3: A read (`req_we`=0) holds the chip selected (`mem_ce_n`=0, `mem_ce2`=1), `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles after acceptance. RD_CYC is the largest of the rounded-up address access time, output-enable access time and read cycle time (11 by default).
- R4: `mem_dq_in` is sampled on the last edge of the read window. `rd_valid` is 1 for exactly one cycle, the (RD_CYC+1)th after acceptance, with that byte on `rd_data`.
- R5: After a read, the chip is deselected with `mem_oe_n`=1 for HZ_CYC cycles (the rounded-up float time, 4 by default) before `req_ready` returns to 1. `mem_dq_oe` is never 1 unless `mem_oe_n` has been 1 on at least HZ_CYC preceding edges.
- R6: A write (`req_we`=1) holds the chip selected, `mem_oe_n`=1, `mem_we_n`=0 and `mem_dq_oe`=1 for WR_CYC cycles, with `mem_dq_out` constant. WR_CYC is the largest of the rounded-up write pulse, address-to-end, select-to-end and data-overlap minimums, and of the rounded-up write cycle time minus one (10 by default).
- R7: In the cycle after the write pulse, `mem_we_n`=1 while the chip stays selected and `mem_dq_oe`=1. `wr_done` pulses in exactly that cycle, and the next cycle is idle.
- R8: `mem_dq_oe` and `mem_oe_n`=0 are never 1 and 0 together. The block never drives the bus while the memory may still be driving it.
- R9: At the memory pins, every write has a low pulse of at least 45 ns, address and select held for at least 50 ns, and data stable for at least 25 ns before the end of the write. Every read holds the address and output enable stable long enough (55 ns and 30 ns) for the sampled byte to be valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the read byte |
| rd_data | output | 8 | Read byte |
| wr_done | output | 1 | One-cycle pulse at the end of a write |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bench's memory model returns a corrupted byte until both the address and output-enable access times have elapsed. A block that samples even one cycle early therefore returns the wrong data. The model counts write pulse, select, address and data-overlap times, and reports a write that ends early or changes data too late, instead of storing it. It also keeps track of how long the memory may go on driving after a read. A block that drives the bus during that float window, or that moves the address or data while busy because the client changed its request, disagrees with the cycle-accurate reference. Reads and writes are issued back to back, with the next request already held valid while the block is busy, so a block that accepts early shows up as well.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state encoding and cycle-rounding helpers for the
// asynchronous static RAM sequencer. Assumes all timings are positive
// integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD     = 3'd1,
        ST_RD_HZ  = 3'd2,
        ST_WR     = 3'd3,
        ST_WR_END = 3'd4
    } state_t;

    // Round a nanosecond figure up to whole clock periods.
    function automatic int ns2cyc(input int ns, input int per_ns);
        return (ns + per_ns - 1) / per_ns;
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Module: down-counting wait timer. A load sets the remaining count and
// expired is high once the count reaches zero. Assumes load values fit
// CNT_W bits.
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
// Module: transaction sequencer. Steps through read, float, write and
// write-recovery phases, loading the wait timer on each phase entry.
// Assumes RD_CYC, WR_CYC and HZ_CYC are at least 1.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int RD_CYC = 11,
    parameter int WR_CYC = 10,
    parameter int HZ_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic             tmr_expired,
    output state_t           state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture
);

    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);

    state_t state_q, state_d;

    // Next-phase selection and timer loading.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = req_we ? WR_LD : RD_LD;
                    state_d  = req_we ? ST_WR : ST_RD;
                end
            end
            ST_RD: begin
                if (tmr_expired) begin
                    capture  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = HZ_LD;
                    state_d  = ST_RD_HZ;
                end
            end
            ST_RD_HZ: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_WR: begin
                if (tmr_expired) state_d = ST_WR_END;
            end
            ST_WR_END: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/sram_ctrl_pindec.sv
// Module: decodes the phase register into memory control pin levels and
// handshake outputs. Pure decode of a registered state, so pins change
// only on clock edges. Assumes the encoding from sram_ctrl_pkg.
module sram_ctrl_pindec
    import sram_ctrl_pkg::*;
(
    input  state_t state,
    output logic   ce_n,
    output logic   ce2,
    output logic   oe_n,
    output logic   we_n,
    output logic   dq_oe,
    output logic   ready,
    output logic   done
);

    // Pin levels per phase; idle and float keep the memory deselected.
    always_comb begin
        ce_n  = 1'b1;
        ce2   = 1'b0;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        dq_oe = 1'b0;
        ready = 1'b0;
        done  = 1'b0;
        case (state)
            ST_IDLE: ready = 1'b1;
            ST_RD: begin
                ce_n = 1'b0;
                ce2  = 1'b1;
                oe_n = 1'b0;
            end
            ST_WR: begin
                ce_n  = 1'b0;
                ce2   = 1'b1;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_END: begin
                ce_n  = 1'b0;
                ce2   = 1'b1;
                dq_oe = 1'b1;
                done  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_ctrl.sv
// Module: asynchronous static RAM sequencer top. Takes one request at a
// time, holds address and write data in registers for the whole
// transaction, and converts nanosecond minimums into cycle counts.
// Assumes the memory's data bus is split into out/oe/in outside.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 5,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 30,
    parameter int T_RC_NS = 55,
    parameter int T_WP_NS = 45,
    parameter int T_AW_NS = 50,
    parameter int T_DW_NS = 25,
    parameter int T_WC_NS = 55,
    parameter int T_HZ_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC = max2(max2(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)),
                                 ns2cyc(T_RC_NS, CLK_NS));
    localparam int WR_CYC = max2(max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                 max2(ns2cyc(T_DW_NS, CLK_NS), ns2cyc(T_WC_NS, CLK_NS) - 1));
    localparam int HZ_CYC = max2(ns2cyc(T_HZ_NS, CLK_NS), 1);
    localparam int CNT_W  = $clog2(max2(max2(RD_CYC, WR_CYC), HZ_CYC) + 1);

    state_t           state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctrl_fsm #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .HZ_CYC (HZ_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .tmr_expired (tmr_expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .capture     (capture)
    );

    sram_ctrl_pindec u_pins (
        .state (state),
        .ce_n  (mem_ce_n),
        .ce2   (mem_ce2),
        .oe_n  (mem_oe_n),
        .we_n  (mem_we_n),
        .dq_oe (mem_dq_oe),
        .ready (req_ready),
        .done  (wr_done)
    );

    // Capture address and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the bus at the end of the read window and flag it for a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rd_data    = rdata_q;
    assign rd_valid   = rvalid_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
// Module: protocol checker bound to sram_ctrl. Watches the pins and
// handshake only. Assumes HZ_CYC matches the bound instance.
module sram_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int HZ_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              wr_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    int oe_hi_cnt;

    // Count edges with output enable high, saturating at the float count.
    always_ff @(posedge clk) begin
        if (!rst_n)         oe_hi_cnt <= HZ_CYC;
        else if (!mem_oe_n) oe_hi_cnt <= 0;
        else if (oe_hi_cnt < HZ_CYC) oe_hi_cnt <= oe_hi_cnt + 1;
    end

    a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

    a_r3_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_ce2 && mem_we_n));

    a_r4_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r5_float_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_hi_cnt >= HZ_CYC));

    a_r6_write_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n && mem_ce2));

    a_r7_done_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> (mem_we_n && mem_dq_oe && $past(!mem_we_n)));

    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .HZ_CYC(HZ_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .wr_done   (wr_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
// Bench: cycle-accurate reference of the handshake and pins, plus a
// behavioural memory that enforces the nanosecond minimums.
module tb_sram_ctrl;

    localparam int PER  = 5;
    localparam int RDC  = (55 + PER - 1) / PER;
    localparam int WRC  = (50 + PER - 1) / PER;
    localparam int HZC  = (20 + PER - 1) / PER;
    localparam int AA_C = (55 + PER - 1) / PER;
    localparam int OE_C = (30 + PER - 1) / PER;
    localparam int WP_C = (45 + PER - 1) / PER;
    localparam int AW_C = (50 + PER - 1) / PER;
    localparam int DW_C = (25 + PER - 1) / PER;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        wr_done;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int vectors = 0;
    int miss_ref = 0;
    int miss_mem = 0;
    bit finished = 1'b0;

    always #(PER / 2.0) clk = ~clk;

    sram_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- behavioural memory ----------------
    logic [7:0] mem_arr [int];
    int a_cnt = 0, sel_cnt = 0, we_cnt = 0, d_cnt = 0, oe_cnt = 0, hold = 0;
    logic [17:0] a_prev = '0;
    logic [7:0]  d_prev = '0;

    function automatic logic [7:0] mem_rd(input logic [17:0] a);
        return mem_arr.exists(int'(a)) ? mem_arr[int'(a)] : 8'h00;
    endfunction

    task automatic mem_fail(input string tag, input int act, input int exp);
        miss_mem++;
        $display("FAIL %s memory model: actual %0d expected >= %0d at %0t", tag, act, exp, $time);
    endtask

    always @(negedge clk) begin
        bit sel, we_act, rd_act, drv;
        sel    = !mem_ce_n && mem_ce2;
        we_act = sel && !mem_we_n;
        if (rst_n && we_cnt > 0 && !we_act) begin
            if (we_cnt < WP_C)  mem_fail("R9 write pulse", we_cnt, WP_C);
            if (sel_cnt < AW_C) mem_fail("R9 select to end", sel_cnt, AW_C);
            if (a_cnt < AW_C)   mem_fail("R9 address to end", a_cnt, AW_C);
            if (d_cnt < DW_C)   mem_fail("R9 data overlap", d_cnt, DW_C);
            mem_arr[int'(mem_addr)] = mem_dq_out;
        end
        a_cnt   = (mem_addr == a_prev) ? a_cnt + 1 : 1;
        a_prev  = mem_addr;
        sel_cnt = sel ? sel_cnt + 1 : 0;
        we_cnt  = we_act ? we_cnt + 1 : 0;
        d_cnt   = mem_dq_oe ? ((mem_dq_out == d_prev && d_cnt > 0) ? d_cnt + 1 : 1) : 0;
        d_prev  = mem_dq_out;
        oe_cnt  = (sel && !mem_oe_n) ? oe_cnt + 1 : 0;
        rd_act  = sel && !mem_oe_n && mem_we_n;
        if (rd_act) begin
            drv = 1'b1; hold = HZC;
        end else if (hold > 0) begin
            drv = 1'b1; hold--;
        end else begin
            drv = 1'b0;
        end
        if (rst_n && drv && mem_dq_oe) mem_fail("R8 bus contention", 1, 0);
        mem_dq_in = (rd_act && a_cnt >= AA_C && oe_cnt >= OE_C) ? mem_rd(mem_addr)
                                                                : ~mem_rd(mem_addr);
    end

    // ---------------- cycle reference ----------------
    logic [7:0] ref_mem [int];
    int          m_kind = 0;   // 0 idle, 1 read, 2 write
    int          m_k = 0;
    logic [17:0] m_addr = '0;
    logic [7:0]  m_data = '0;

    function automatic logic [7:0] ref_rd(input logic [17:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        if (!ok) begin
            miss_ref++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit rd, wr, e_sel, e_oen, e_wen, e_dqoe, e_rdy, e_rdv, e_done;
        if (!finished) begin
            vectors++;
            if (!rst_n) begin
                // R1 reset state
                chk(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready,
                    "R1 reset pins", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
            end else begin
                rd     = (m_kind == 1);
                wr     = (m_kind == 2);
                e_sel  = (rd && m_k <= RDC) || (wr && m_k <= WRC + 1);
                e_oen  = !(rd && m_k <= RDC);
                e_wen  = !(wr && m_k <= WRC);
                e_dqoe = wr && m_k <= WRC + 1;
                e_rdy  = (m_kind == 0);
                e_rdv  = rd && m_k == RDC + 1;
                e_done = wr && m_k == WRC + 1;
                chk(req_ready == e_rdy, "R1/R2 req_ready", req_ready, e_rdy);
                chk((!mem_ce_n && mem_ce2) == e_sel && mem_ce_n == !mem_ce2,
                    "R1/R3/R5 chip select", {mem_ce_n, mem_ce2}, {!e_sel, e_sel});
                chk(mem_oe_n == e_oen, "R3/R5 mem_oe_n", mem_oe_n, e_oen);
                chk(mem_we_n == e_wen, "R6 mem_we_n", mem_we_n, e_wen);
                chk(mem_dq_oe == e_dqoe, "R6/R7 mem_dq_oe", mem_dq_oe, e_dqoe);
                chk(rd_valid == e_rdv, "R4 rd_valid", rd_valid, e_rdv);
                chk(wr_done == e_done, "R7 wr_done", wr_done, e_done);
                if (e_sel) chk(mem_addr == m_addr, "R2 mem_addr held", mem_addr, m_addr);
                if (e_dqoe) chk(mem_dq_out == m_data, "R2/R6 mem_dq_out held", mem_dq_out, m_data);
                if (e_rdv) chk(rd_data == ref_rd(m_addr), "R4 rd_data", rd_data, ref_rd(m_addr));
                // advance the reference to the next cycle
                if (m_kind == 0) begin
                    if (req_valid) begin
                        m_kind = req_we ? 2 : 1;
                        m_k    = 1;
                        m_addr = req_addr;
                        m_data = req_wdata;
                        if (req_we) ref_mem[int'(req_addr)] = req_wdata;
                    end
                end else begin
                    m_k++;
                    if ((rd && m_k > RDC + HZC) || (wr && m_k > WRC + 1)) m_kind = 0;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit we, input logic [17:0] a, input logic [7:0] d);
        logic rdy;
        @(posedge clk); #1;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk); rdy = req_ready;
            @(posedge clk);
        end while (!rdy);
        #1 req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d;   // R2: changes after acceptance must not leak
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss_ref + miss_mem);
    endtask

    initial begin
        #(200000 * PER);
        miss_ref++;
        $display("FAIL watchdog: run did not complete");
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        issue(1'b0, 18'h00000, 8'h00);        // R4 read of unwritten word
        issue(1'b1, 18'h3FFFF, 8'hA5);        // R6 top address
        issue(1'b1, 18'h00000, 8'h5A);        // R2 queued while busy
        issue(1'b0, 18'h3FFFF, 8'h00);        // R3/R4 read back
        issue(1'b0, 18'h00000, 8'h00);
        issue(1'b1, 18'h15555, 8'hFF);
        issue(1'b0, 18'h15555, 8'h00);
        issue(1'b1, 18'h15555, 8'h00);        // R7 overwrite
        issue(1'b0, 18'h15555, 8'h00);
        repeat (7) @(posedge clk);            // R1 idle gap
        for (int i = 0; i < 24; i++) begin
            issue(1'b1, 18'((i * 7919) & 18'h3FFFF), 8'((i * 37) + 3));
        end
        for (int i = 23; i >= 0; i--) begin
            issue(1'b0, 18'((i * 7919) & 18'h3FFFF), 8'h00);
            if (i % 5 == 0) issue(1'b1, 18'((i * 7919) & 18'h3FFFF), 8'(i + 200));  // R8 read-to-write turnaround
        end
        repeat (30) @(posedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule